// File: doc/BRIEF.md
# Packed Alignment Min/Max Unit

This unit speeds up the cell update at the heart of sequence-alignment dynamic programming. Each 32-bit operand carries two signed 16-bit score lanes. A 3-bit opcode picks one fused operation, and the unit applies it to both lanes in parallel and independently. There are two operation families. The first adds two scores and compares the sum against a third operand. The second takes the maximum or minimum of three scores. Some forms then clamp a negative outcome to zero, which suits local alignment. Lane sums saturate instead of wrapping.

A caller presents a, b and c with the opcode and raises `in_valid`. One clock later the packed answer appears on `result` with `out_valid` high. The output register is a two-state machine. OUT_IDLE means nothing new was captured. OUT_FRESH means a result was captured on the last edge. An edge with `in_valid` high moves it to OUT_FRESH, from either state. An edge with `in_valid` low moves it to OUT_IDLE. Reset forces OUT_IDLE.

Top module: `dp_minmax_alu`

## Requirements
- R1: The lower lane is bits 15:0 and the upper lane is bits 31:16 of every operand and of `result`. Each lane is computed only from the same lane of the operands: no carry, saturation or compare outcome crosses between lanes.
- R2: Opcode 0 gives max(min(sat(a+b), c), 0) per lane. Opcode 1 gives min(sat(a+b), c) with no clamp.
- R3: Opcode 2 gives max(max(sat(a+b), c), 0) per lane. Opcode 3 gives max(sat(a+b), c) with no clamp.
- R4: Opcode 4 gives max(a, b, c, 0) per lane. Opcode 5 gives max(a, b, c) per lane.
- R5: Opcode 6 gives min(a, b, c) per lane, with no clamp.
- R6: The per-lane sum a+b saturates to the range -32768..32767 before any compare. A positive overflow gives 32767 and a negative overflow gives -32768.
- R7: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was high. `result` is updated at that same edge.
- R8: While `in_valid` is low, `result` keeps its last value and `out_valid` is low.
- R9: A synchronous active-high `rst` clears `result` to zero and drives `out_valid` and `op_err` low.
- R10: Opcode 7 is undefined. Accepting it gives a zero `result` and raises `op_err` for that single output cycle, together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| opcode | input | 3 | Operation select, 0..6 defined, 7 undefined |
| op_a | input | 32 | Packed operand a, two signed 16-bit lanes |
| op_b | input | 32 | Packed operand b |
| op_c | input | 32 | Packed operand c |
| out_valid | output | 1 | Result captured on the previous edge |
| result | output | 32 | Packed registered result |
| op_err | output | 1 | Undefined opcode was accepted on the previous edge |

## Verification
Every defined opcode is driven with a full sweep of the corner scores -32768, 32767, 0 and -1, plus small mixed-sign values. The two lanes always carry different scores, so a lane swap or a leak between lanes shows up as a mismatch. Pairs that reach both ends of the 16-bit range separate saturation from wraparound. Negative outcomes separate the clamped forms from the unclamped ones. A seeded pseudo-random stream covers ordinary scores. Idle gaps, reset in mid-stream and the undefined opcode test the hold, clear and error paths.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

    localparam int LANE_W  = 16;
    localparam int N_LANES = 2;
    localparam int DATA_W  = LANE_W * N_LANES;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADDMIN_Z = 3'd0,
        OP_ADDMIN   = 3'd1,
        OP_ADDMAX_Z = 3'd2,
        OP_ADDMAX   = 3'd3,
        OP_MAX3_Z   = 3'd4,
        OP_MAX3     = 3'd5,
        OP_MIN3     = 3'd6,
        OP_UNDEF    = 3'd7
    } dp_op_e;

    typedef struct packed {
        logic use_sum;   // first term is sat(a+b), compared against c
        logic pick_max;  // max tree rather than min tree
        logic clamp;     // floor the outcome at zero
        logic illegal;   // opcode has no meaning
    } dp_ctrl_t;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_FRESH = 1'b1
    } out_state_e;

endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
    import dpalu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dp_ctrl_t        ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (dp_op_e'(opcode))
            OP_ADDMIN_Z: begin ctrl.use_sum = 1'b1; ctrl.clamp = 1'b1; end
            OP_ADDMIN:   begin ctrl.use_sum = 1'b1; end
            OP_ADDMAX_Z: begin ctrl.use_sum = 1'b1; ctrl.pick_max = 1'b1; ctrl.clamp = 1'b1; end
            OP_ADDMAX:   begin ctrl.use_sum = 1'b1; ctrl.pick_max = 1'b1; end
            OP_MAX3_Z:   begin ctrl.pick_max = 1'b1; ctrl.clamp = 1'b1; end
            OP_MAX3:     begin ctrl.pick_max = 1'b1; end
            OP_MIN3:     begin ctrl.pick_max = 1'b0; end
            OP_UNDEF:    begin ctrl.illegal = 1'b1; end
            default:     begin ctrl.illegal = 1'b1; end
        endcase
    end

endmodule

// File: rtl/dpalu_lane.sv
module dpalu_lane
    import dpalu_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  dp_ctrl_t              ctrl,
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic signed [W-1:0]   c,
    output logic signed [W-1:0]   y
);

    localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0]   wide_sum;
    logic signed [W-1:0] sat_sum;
    logic signed [W-1:0] t0, t1, stage1, stage2;

    // saturating add: overflow when the two top bits of the wide sum differ
    always_comb begin
        wide_sum = {a[W-1], a} + {b[W-1], b};
        if (wide_sum[W] != wide_sum[W-1])
            sat_sum = wide_sum[W] ? S_MIN : S_MAX;
        else
            sat_sum = wide_sum[W-1:0];
    end

    always_comb begin
        t0 = ctrl.use_sum ? sat_sum : a;
        t1 = ctrl.use_sum ? c       : b;

        if (ctrl.pick_max) stage1 = (t0 > t1) ? t0 : t1;
        else               stage1 = (t0 < t1) ? t0 : t1;

        if (ctrl.use_sum)       stage2 = stage1;
        else if (ctrl.pick_max) stage2 = (stage1 > c) ? stage1 : c;
        else                    stage2 = (stage1 < c) ? stage1 : c;

        if (ctrl.clamp && stage2[W-1]) y = '0;
        else                           y = stage2;
    end

endmodule

// File: rtl/dp_minmax_alu.sv
module dp_minmax_alu
    import dpalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              op_err
);

    dp_ctrl_t          ctrl;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] next_res;
    out_state_e        state_q, state_d;

    dpalu_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dpalu_lane #(.W(LANE_W)) u_lane (
            .ctrl (ctrl),
            .a    (op_a[g*LANE_W +: LANE_W]),
            .b    (op_b[g*LANE_W +: LANE_W]),
            .c    (op_c[g*LANE_W +: LANE_W]),
            .y    (lane_res[g*LANE_W +: LANE_W])
        );
    end

    assign next_res = ctrl.illegal ? '0 : lane_res;

    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_FRESH : OUT_IDLE;
            OUT_FRESH: state_d = in_valid ? OUT_FRESH : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            op_err <= 1'b0;
        end else begin
            op_err <= in_valid && ctrl.illegal;
            if (in_valid) result <= next_res;
        end
    end

    assign out_valid = (state_q == OUT_FRESH);

endmodule

// File: rtl/dp_minmax_alu_chk.sv
module dp_minmax_alu_chk
    import dpalu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   opcode,
    input logic [DATA_W-1:0] result,
    input logic              out_valid,
    input logic              op_err
);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !op_err && result == '0));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (out_valid && result == '0));

    a_r10_err_raised: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OP_UNDEF) |=> op_err);

    a_r2_clamp_nonneg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OP_ADDMIN_Z) |=> (!result[LANE_W-1] && !result[DATA_W-1]));

    a_r4_clamp_nonneg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == OP_MAX3_Z) |=> (!result[LANE_W-1] && !result[DATA_W-1]));

endmodule

bind dp_minmax_alu dp_minmax_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .result    (result),
    .out_valid (out_valid),
    .op_err    (op_err)
);

// File: tb/dp_minmax_alu_bench.sv
module dp_minmax_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        op_err;

    int checks = 0;
    int fails  = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_res = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_minmax_alu u_dp_minmax_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .result(result), .op_err(op_err)
    );

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int mx(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int mn(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    function automatic logic [15:0] lane_model(input int op, input logic [15:0] a,
                                               input logic [15:0] b, input logic [15:0] c);
        int sa, sb, sc, r;
        sa = int'($signed(a)); sb = int'($signed(b)); sc = int'($signed(c));
        case (op)
            0: r = mx(mn(sat16(sa + sb), sc), 0);
            1: r = mn(sat16(sa + sb), sc);
            2: r = mx(mx(sat16(sa + sb), sc), 0);
            3: r = mx(sat16(sa + sb), sc);
            4: r = mx(mx(mx(sa, sb), sc), 0);
            5: r = mx(mx(sa, sb), sc);
            6: r = mn(mn(sa, sb), sc);
            default: r = 0;
        endcase
        return r[15:0];
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            6:    return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: present one operation and queue its expected outcome
    task automatic drive(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input string tag);
        logic [31:0] e;
        @(negedge clk);
        in_valid = 1'b1; opcode = op[2:0]; op_a = a; op_b = b; op_c = c;
        e = {lane_model(op, a[31:16], b[31:16], c[31:16]),
             lane_model(op, a[15:0],  b[15:0],  c[15:0])};
        exp_q.push_back({op == 7, e});
        tag_q.push_back(tag);
        last_res = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected out_valid", 33'd1, 33'd0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {op_err, result}, e);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] corner[6];
        logic [31:0] lfsr;
        corner[0] = 16'h8000; corner[1] = 16'h7FFF; corner[2] = 16'h0000;
        corner[3] = 16'hFFFF; corner[4] = 16'h0005; corner[5] = 16'hFFF9;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", {op_err, out_valid, result}, 33'd0);
        rst = 1'b0;

        // R6: saturation in both directions, R1: lanes saturate independently
        drive(3, {16'h0001, 16'h7FFF}, {16'h0002, 16'h0001}, {16'h8000, 16'h8000}, "R6 pos sat / R1");
        drive(1, {16'h8000, 16'h0003}, {16'hFFFF, 16'h0004}, {16'h7FFF, 16'h7FFF}, "R6 neg sat / R1");
        drive(2, {16'h7FFF, 16'h8000}, {16'h7FFF, 16'h8000}, {16'h0000, 16'h8000}, "R6 clamp sat");
        // R1: upper-lane-only negative, lower positive
        drive(6, {16'hFFFF, 16'h0010}, {16'h0002, 16'h0020}, {16'h0003, 16'h0030}, "R1 lane split");
        // R10: undefined opcode mid-stream
        drive(7, 32'h12345678, 32'h0, 32'h0, "R10 undefined");
        drive(0, {16'h0003, 16'hFFF0}, {16'h0004, 16'h0001}, {16'h0010, 16'h0010}, "R2 after err");

        // corner sweep for every defined opcode
        for (int op = 0; op < 7; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int k = 0; k < 6; k++)
                        drive(op, {corner[5-i], corner[i]}, {corner[(j+1)%6], corner[j]},
                              {corner[(k+3)%6], corner[k]}, op_tag(op));

        // pseudo-random stream
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb, rc;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; ra = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; rb = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223; rc = lfsr;
            drive(n % 8, ra, rb, rc, op_tag(n % 8));
        end

        // R8: hold while idle, checked after the final result is out
        idle(1);
        idle(3);
        check("R8 hold result", {1'b0, result}, {1'b0, last_res});
        check("R8 valid low", {32'd0, out_valid}, 33'd0);
        check("R7 queue drained", 33'(exp_q.size()), 33'd0);

        // R7: single issue gives a single-cycle strobe
        drive(5, {16'h0001, 16'h0002}, {16'h0003, 16'h0004}, {16'h0005, 16'h0006}, "R4 single");
        idle(1);
        @(negedge clk);
        check("R7 strobe one cycle", {32'd0, out_valid}, 33'd0);

        // R9: reset mid-stream clears everything
        drive(3, 32'h00100010, 32'h00010001, 32'h0, "R3 pre-reset");
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 mid-stream reset", {op_err, out_valid, result}, 33'd0);
        rst = 1'b0;
        idle(2);
        check("R9 stays clear", {op_err, out_valid, result}, 33'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule